// File: doc/BRIEF.md
# Circular Register-Ring Operand Stack

This block is the operand stack of a small stack-oriented processor. Entries live in a fixed ring of data registers. Two index registers sit over that ring. The top index points at the newest entry. The overflow index marks the slot just below the oldest live entry. The number of live entries is the distance from the overflow index to the top index, modulo the ring size. The ring size must be a power of two, and at most one less than the ring size can be live at once.

Each unstalled clock applies one 2-bit stack operation together with a next-value input. The top and second-from-top entries are shown on the outputs, and an absent entry reads as zero.

A push onto a full ring drops the oldest entry and raises an overflow flag. A pop from an empty stack, or a swap with fewer than two entries, raises an underflow flag. Either flag can be turned into a spill or fill request by a spill-enable input. Moving data to and from memory is left to the surrounding logic.

Top module: `stk_ring_stack`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) empties the stack, so that top_o and second_o read 0 and ovf_o, udf_o, spill_req_o and fill_req_o are 0.
- R2: Operation code 01 (push) makes next_i the new top. The previous top becomes second, and all older entries keep their order.
- R3: Operation code 10 (pop) on a non-empty stack removes the top entry, and the entry below it becomes the top.
- R4: Operation code 11 (swap) with two or more entries exchanges the top and second entries and leaves the depth unchanged.
- R5: Operation code 00 (nop) leaves every entry and the depth unchanged.
- R6: A push onto an empty stack leaves exactly one entry: top_o shows the pushed value and second_o reads 0.
- R7: A push onto a full stack (ring size minus one entries, 15 by default) raises ovf_o for the following cycle. The oldest entry is discarded and the depth stays at the maximum.
- R8: A pop on an empty stack raises udf_o for the following cycle and changes nothing else.
- R9: A swap with fewer than two entries raises udf_o for the following cycle and changes nothing else.
- R10: While stall is high, no register changes: the entries, the depth and both flags hold their values.
- R11: spill_req_o equals ovf_o while spill_en is high, and fill_req_o equals udf_o while spill_en is high. Both are 0 while spill_en is low.
- R12: An unstalled operation that causes no overflow or underflow clears ovf_o and udf_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Holds all state when high |
| spill_en | input | 1 | Lets the flags raise memory requests |
| op_i | input | 2 | Stack operation: 00 nop, 01 push, 10 pop, 11 swap |
| next_i | input | DATA_W | Value written by a push |
| top_o | output | DATA_W | Top entry, or 0 when the stack is empty |
| second_o | output | DATA_W | Entry below the top, or 0 when fewer than two entries |
| ovf_o | output | 1 | The last operation discarded the oldest entry |
| udf_o | output | 1 | The last operation found too few entries |
| spill_req_o | output | 1 | Request to write the lost entry to memory |
| fill_req_o | output | 1 | Request to read a missing entry from memory |

## Verification
A bad top index shows at once on top_o, one cycle after the operation that moved it. A bad overflow index stays hidden until the depth matters. It shows up when second_o reads 0 too early, when an underflow is missed or raised wrongly, or when a full ring misses its overflow. The bench therefore drains the stack completely after filling it past capacity. A wrongly written or swapped ring register shows when that entry reaches the top, which is why every pop and swap result is compared.

// File: rtl/stk_pkg.sv
package stk_pkg;

    typedef enum logic [1:0] {
        STK_NOP  = 2'b00,
        STK_PUSH = 2'b01,
        STK_POP  = 2'b10,
        STK_SWAP = 2'b11
    } stk_op_e;

endpackage

// File: rtl/stk_index_ctrl.sv
module stk_index_ctrl
    import stk_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  stk_op_e          op,
    input  logic [IDX_W-1:0] tp,
    input  logic [IDX_W-1:0] ov,
    output logic [IDX_W-1:0] tp_n,
    output logic [IDX_W-1:0] ov_n,
    output logic             ovf,
    output logic             udf,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic             sw_en,
    output logic [IDX_W-1:0] below_idx
);

    localparam logic [IDX_W-1:0] ONE    = IDX_W'(1);
    localparam logic [IDX_W-1:0] FULL_N = {IDX_W{1'b1}};

    logic [IDX_W-1:0] depth;
    logic             is_empty;
    logic             is_full;
    logic             has_two;

    assign depth     = tp - ov;
    assign is_empty  = (depth == '0);
    assign is_full   = (depth == FULL_N);
    assign has_two   = !is_empty && (depth != ONE);
    assign wr_idx    = tp + ONE;
    assign below_idx = tp - ONE;

    always_comb begin
        tp_n  = tp;
        ov_n  = ov;
        ovf   = 1'b0;
        udf   = 1'b0;
        wr_en = 1'b0;
        sw_en = 1'b0;
        unique case (op)
            STK_PUSH: begin
                tp_n  = tp + ONE;
                wr_en = 1'b1;
                if (is_full) begin
                    ov_n = ov + ONE;
                    ovf  = 1'b1;
                end
            end
            STK_POP: begin
                if (is_empty) udf  = 1'b1;
                else          tp_n = tp - ONE;
            end
            STK_SWAP: begin
                if (has_two) sw_en = 1'b1;
                else         udf   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/stk_ring.sv
module stk_ring #(
    parameter int DATA_W     = 16,
    parameter int RING_DEPTH = 16,
    parameter int IDX_W      = $clog2(RING_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              sw_en,
    input  logic [IDX_W-1:0]  hi_idx,
    input  logic [IDX_W-1:0]  lo_idx,
    output logic [DATA_W-1:0] hi_data,
    output logic [DATA_W-1:0] lo_data
);

    logic [DATA_W-1:0] mem_q [RING_DEPTH];
    logic [DATA_W-1:0] mem_d [RING_DEPTH];

    assign hi_data = mem_q[hi_idx];
    assign lo_data = mem_q[lo_idx];

    always_comb begin
        for (int i = 0; i < RING_DEPTH; i++) begin
            mem_d[i] = mem_q[i];
        end
        if (wr_en) begin
            mem_d[wr_idx] = wr_data;
        end else if (sw_en) begin
            mem_d[hi_idx] = mem_q[lo_idx];
            mem_d[lo_idx] = mem_q[hi_idx];
        end
    end

    generate
        for (genvar g = 0; g < RING_DEPTH; g++) begin : g_cell
            always_ff @(posedge clk) begin
                if (rst) mem_q[g] <= '0;
                else     mem_q[g] <= mem_d[g];
            end
        end
    endgenerate

endmodule

// File: rtl/stk_ring_stack.sv
module stk_ring_stack
    import stk_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int RING_DEPTH = 16,
    parameter int IDX_W      = $clog2(RING_DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              stall,
    input  logic              spill_en,
    input  logic [1:0]        op_i,
    input  logic [DATA_W-1:0] next_i,
    output logic [DATA_W-1:0] top_o,
    output logic [DATA_W-1:0] second_o,
    output logic              ovf_o,
    output logic              udf_o,
    output logic              spill_req_o,
    output logic              fill_req_o
);

    localparam logic [IDX_W-1:0] ONE = IDX_W'(1);

    typedef struct packed {
        logic [IDX_W-1:0] tp;
        logic [IDX_W-1:0] ov;
        logic             ovf;
        logic             udf;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic [IDX_W-1:0]  tp_q, ov_q, tp_n, ov_n, wr_idx, below_idx, depth_q;
    logic              ovf_n, udf_n, wr_req, sw_req;
    logic [DATA_W-1:0] hi_data, lo_data;

    assign tp_q    = st_q.tp;
    assign ov_q    = st_q.ov;
    assign depth_q = tp_q - ov_q;

    stk_index_ctrl #(.IDX_W(IDX_W)) u_idx (
        .op        (stk_op_e'(op_i)),
        .tp        (tp_q),
        .ov        (ov_q),
        .tp_n      (tp_n),
        .ov_n      (ov_n),
        .ovf       (ovf_n),
        .udf       (udf_n),
        .wr_en     (wr_req),
        .wr_idx    (wr_idx),
        .sw_en     (sw_req),
        .below_idx (below_idx)
    );

    stk_ring #(.DATA_W(DATA_W), .RING_DEPTH(RING_DEPTH), .IDX_W(IDX_W)) u_ring (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_req && !stall),
        .wr_idx  (wr_idx),
        .wr_data (next_i),
        .sw_en   (sw_req && !stall),
        .hi_idx  (tp_q),
        .lo_idx  (below_idx),
        .hi_data (hi_data),
        .lo_data (lo_data)
    );

    always_comb begin
        st_d = st_q;
        if (!stall) begin
            st_d.tp  = tp_n;
            st_d.ov  = ov_n;
            st_d.ovf = ovf_n;
            st_d.udf = udf_n;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign top_o       = (depth_q != '0)  ? hi_data : '0;
    assign second_o    = (depth_q != '0 && depth_q != ONE) ? lo_data : '0;
    assign ovf_o       = st_q.ovf;
    assign udf_o       = st_q.udf;
    assign spill_req_o = st_q.ovf && spill_en;
    assign fill_req_o  = st_q.udf && spill_en;

endmodule

// File: rtl/stk_ring_stack_chk.sv
module stk_ring_stack_chk #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              stall,
    input logic              spill_en,
    input logic [1:0]        op_i,
    input logic [DATA_W-1:0] next_i,
    input logic [DATA_W-1:0] top_o,
    input logic [DATA_W-1:0] second_o,
    input logic              ovf_o,
    input logic              udf_o,
    input logic              spill_req_o,
    input logic              fill_req_o,
    input logic [IDX_W-1:0]  tp_q,
    input logic [IDX_W-1:0]  ov_q
);

    logic [IDX_W-1:0] tp_inc;
    logic [IDX_W-1:0] ov_prev_inc;
    assign tp_inc = tp_q + IDX_W'(1);

    always_ff @(posedge clk) ov_prev_inc <= ov_q + IDX_W'(1);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (top_o == '0 && second_o == '0 && !ovf_o && !udf_o));

    // R2
    push_top_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && op_i == 2'b01) |=> top_o == $past(next_i));

    // R7
    full_push_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && op_i == 2'b01 && tp_inc == ov_q) |=> (ovf_o && ov_q == ov_prev_inc));

    // R8
    empty_pop_udf_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && op_i == 2'b10 && tp_q == ov_q) |=> (udf_o && $stable(tp_q) && $stable(ov_q)));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(tp_q) && $stable(ov_q) && $stable(top_o) && $stable(ovf_o) && $stable(udf_o)));

    // R11
    spill_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !spill_en |-> (!spill_req_o && !fill_req_o));

    // R12
    nop_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!stall && op_i == 2'b00) |=> (!ovf_o && !udf_o));

endmodule

bind stk_ring_stack stk_ring_stack_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .stall       (stall),
    .spill_en    (spill_en),
    .op_i        (op_i),
    .next_i      (next_i),
    .top_o       (top_o),
    .second_o    (second_o),
    .ovf_o       (ovf_o),
    .udf_o       (udf_o),
    .spill_req_o (spill_req_o),
    .fill_req_o  (fill_req_o),
    .tp_q        (tp_q),
    .ov_q        (ov_q)
);

// File: tb/stk_ring_stack_test.sv
`timescale 1ns/1ps
module stk_ring_stack_test;

    localparam int W   = 16;
    localparam int CAP = 15;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         stall = 1'b0;
    logic         spill_en = 1'b0;
    logic [1:0]   op_i = 2'b00;
    logic [W-1:0] next_i = '0;
    logic [W-1:0] top_o, second_o;
    logic         ovf_o, udf_o, spill_req_o, fill_req_o;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [W-1:0] q[$];
    logic eo = 1'b0;
    logic eu = 1'b0;

    always #10 clk = ~clk;

    stk_ring_stack uut (
        .clk(clk), .rst(rst), .stall(stall), .spill_en(spill_en),
        .op_i(op_i), .next_i(next_i), .top_o(top_o), .second_o(second_o),
        .ovf_o(ovf_o), .udf_o(udf_o), .spill_req_o(spill_req_o), .fill_req_o(fill_req_o)
    );

    task automatic chk(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare(string tag);
        chk(tag, "top", top_o, q.size() > 0 ? q[0] : '0);
        chk(tag, "second", second_o, q.size() > 1 ? q[1] : '0);
        chk(tag, "ovf", W'(ovf_o), W'(eo));
        chk(tag, "udf", W'(udf_o), W'(eu));
        chk("R11", "spill_req", W'(spill_req_o), W'(eo & spill_en));
        chk("R11", "fill_req", W'(fill_req_o), W'(eu & spill_en));
    endtask

    task automatic model();
        logic [W-1:0] t;
        if (rst) begin
            q.delete(); eo = 0; eu = 0;
        end else if (!stall) begin
            eo = 0; eu = 0;
            case (op_i)
                2'b01: begin
                    if (q.size() == CAP) begin void'(q.pop_back()); eo = 1; end
                    q.push_front(next_i);
                end
                2'b10: if (q.size() == 0) eu = 1; else void'(q.pop_front());
                2'b11: if (q.size() < 2) eu = 1;
                       else begin t = q[0]; q[0] = q[1]; q[1] = t; end
                default: ;
            endcase
        end
    endtask

    task automatic cyc(logic [1:0] op, logic [W-1:0] v, logic st, logic sp, string tag);
        op_i = op; next_i = v; stall = st; spill_en = sp;
        @(posedge clk);
        model();
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        @(posedge clk); model(); @(posedge clk); model();
        @(negedge clk);
        compare("R1");
        rst = 1'b0;
        cyc(2'b01, 16'h1111, 0, 0, "R6");
        cyc(2'b11, 16'h0, 0, 1, "R9");
        cyc(2'b01, 16'h2222, 0, 1, "R12");
        cyc(2'b01, 16'h3333, 0, 0, "R2");
        cyc(2'b11, 16'h0, 0, 0, "R4");
        cyc(2'b00, 16'hdead, 0, 0, "R5");
        cyc(2'b10, 16'h0, 0, 0, "R3");
        cyc(2'b10, 16'h0, 0, 0, "R3");
        cyc(2'b10, 16'h0, 0, 0, "R3");
        cyc(2'b10, 16'h0, 0, 1, "R8");
        cyc(2'b01, 16'h0, 1, 1, "R10");
        cyc(2'b10, 16'h0, 0, 0, "R8");
        cyc(2'b00, 16'h0, 0, 0, "R12");
        for (int i = 0; i < 18; i++) cyc(2'b01, W'(16'h100 + i), 0, 1, i >= CAP ? "R7" : "R2");
        cyc(2'b10, 16'h0, 1, 1, "R10");
        cyc(2'b00, 16'h0, 1, 0, "R10");
        for (int i = 0; i < 16; i++) cyc(2'b10, 16'h0, 0, 1, i == 15 ? "R8" : "R3");
        rst = 1'b1;
        cyc(2'b00, 16'h0, 0, 0, "R1");
        rst = 1'b0;
        for (int i = 0; i < 600; i++) begin
            logic [1:0] op;
            string tag;
            op = 2'($urandom_range(0, 3));
            case (op)
                2'b00: tag = "R5";
                2'b01: tag = (q.size() == CAP) ? "R7" : "R2";
                2'b10: tag = (q.size() == 0) ? "R8" : "R3";
                default: tag = (q.size() < 2) ? "R9" : "R4";
            endcase
            cyc(op, W'($urandom), ($urandom_range(0, 7) == 0), 1'($urandom), tag);
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule